// File: doc/BRIEF.md
# SMRAM and TSEG Access Router

This block sits beside the host bridge's memory decoder and decides where each memory access goes. It does not forward the access itself. It holds two control bytes: a main SMRAM control byte and an extended control byte. From these bytes, the access address, the system-management-mode (SMM) flag of the requester and a top-of-low-memory value, it produces a two-bit route code: DRAM, PCI/legacy space, black-hole responder, or not claimed. It covers three address ranges:

- the 128 KiB legacy window at 0xA0000–0xBFFFF;
- that window's high alias at 0xFEDA0000–0xFEDBFFFF, which maps onto the same DRAM bytes;
- a TSEG region directly below top-of-low-memory.

Firmware programs the bytes during boot and then sets the lock bit. From that point the ranges are frozen until reset. Non-SMM code then sees TSEG as a black hole: reads return all ones and writes are dropped. SMM code reaches the DRAM behind it.

Top module: `smram_guard`

## Requirements
- R1: After reset the main byte reads 0x02, the extended byte reads 0x00, rspValid is 0, rspRoute is 3 (not claimed) and holeData is 0.
- R2: While unlocked, the main byte has bits 6 (open), 5 (closed), 4 (lock) and 3 (global enable) writable, and bits 2:0 always read 010. The extended byte has bit 7 (high enable), bits 2:1 (TSEG size) and bit 0 (TSEG enable) writable, and bits 6:3 always read 0. cfgSel 0 selects the main byte and cfgSel 1 selects the extended byte.
- R3: A write that leaves the lock bit set clears the open bit in that same write. The lock bit cannot be cleared until reset. While locked, only the closed bit of the main byte accepts writes, and writes to the extended byte are ignored.
- R4: For a non-SMM access with open set, the low window routes to DRAM when high enable is 0. When high enable is 1, the low window routes to PCI and the high alias routes to DRAM.
- R5: For a non-SMM access with open clear, the low window routes to PCI and the high alias is not claimed. With open set and high enable 0, the high alias is also not claimed.
- R6: For an SMM access with global enable set, the low window routes to DRAM when high enable is 0, and the high alias routes to DRAM when high enable is 1. Every other SMM access to these two ranges, including all of them when global enable is clear, follows the non-SMM rules.
- R7: When TSEG enable is 1, the TSEG size is 1 MiB (code 00), 2 MiB (01) or 8 MiB (10), and code 11 gives size zero, which turns TSEG off. TSEG covers addresses from topOfLow minus the size up to topOfLow-1. TSEG is also off when TSEG enable is 0.
- R8: An access inside TSEG routes to the black hole (code 2) when it is non-SMM, and to DRAM when it is SMM. TSEG takes precedence over the other two ranges.
- R9: Route codes are DRAM=0, PCI=1, black hole=2, not claimed=3. The route, rspValid and holeData are registered one clock after reqValid is sampled. For a black-hole route, holeData is the full 32-bit word of ones, whatever the access width. For any other route it is 0. Addresses outside all three ranges are not claimed.
- R10: A control write sampled on one edge governs a request sampled on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control byte write strobe |
| cfgSel | input | 1 | 0 = main byte, 1 = extended byte |
| cfgWrData | input | 8 | Write data |
| smramByte | output | 8 | Current main control byte |
| extByte | output | 8 | Current extended control byte |
| topOfLow | input | 32 | Top of low DRAM (TSEG upper bound, exclusive) |
| reqValid | input | 1 | Access presented this cycle |
| reqAddr | input | 32 | Access byte address |
| reqSmm | input | 1 | Access made in system management mode |
| rspValid | output | 1 | Route result valid |
| rspRoute | output | 2 | Route code |
| holeData | output | 32 | Black-hole read data |

## Verification
The bench sweeps every combination of open, global enable, high enable, SMM flag, TSEG enable and TSEG size. For each combination it probes the first and last byte of every range and the bytes just outside them, including both TSEG edges for each size.

Several faults show up directly in this sweep:
- Swapping the high-enable sense in either view sends the legacy window to the wrong target.
- An off-by-one TSEG bound leaks DRAM to non-SMM code, or blocks the byte just below the region.
- Mis-decoding size code 11 turns on a TSEG that should be off.

The lock sequence checks that the open bit falls in the same write that sets lock, and that the extended byte stays frozen. A design that only masks later writes would leave the legacy window open to non-SMM code.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_HOLE = 2'd2,
    ROUTE_NONE = 2'd3
  } route_e;

  // main control byte fields
  localparam int OPEN_BIT   = 6;
  localparam int CLOSED_BIT = 5;
  localparam int LOCK_BIT   = 4;
  localparam int GLOBAL_BIT = 3;
  // extended control byte fields
  localparam int HIGH_BIT   = 7;
  localparam int TSIZE_LSB  = 1;
  localparam int TEN_BIT    = 0;

  localparam logic [7:0] MAIN_RESET  = 8'h02;
  localparam logic [7:0] EXT_RESET   = 8'h00;
  localparam logic [7:0] MAIN_MASK   = 8'h78;
  localparam logic [7:0] MAIN_MASK_L = 8'h20;
  localparam logic [7:0] EXT_MASK    = 8'h87;
  localparam logic [7:0] EXT_MASK_L  = 8'h00;

  typedef struct packed {
    logic       openEn;
    logic       globalEn;
    logic       highEn;
    logic       tsegEn;
    logic [1:0] tsegSize;
  } ctl_strobes_t;

endpackage

// File: rtl/smram_guard_ctl.sv
module smram_guard_ctl
  import smram_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         cfgSel,
  input  logic [7:0]   cfgWrData,
  output logic [7:0]   smramByte,
  output logic [7:0]   extByte,
  output ctl_strobes_t strobes
);

  logic [7:0] mainQ, extQ, mainNext, extNext, mainMask, extMask;
  logic       locked;

  assign locked   = mainQ[LOCK_BIT];
  assign mainMask = locked ? MAIN_MASK_L : MAIN_MASK;
  assign extMask  = locked ? EXT_MASK_L  : EXT_MASK;

  always_comb begin
    mainNext = (mainQ & ~mainMask) | (cfgWrData & mainMask);
    if (mainNext[LOCK_BIT]) mainNext[OPEN_BIT] = 1'b0;
    extNext  = (extQ & ~extMask) | (cfgWrData & extMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainQ <= MAIN_RESET;
      extQ  <= EXT_RESET;
    end else if (cfgWrEn) begin
      if (!cfgSel) mainQ <= mainNext;
      else         extQ  <= extNext;
    end
  end

  assign smramByte         = mainQ;
  assign extByte           = extQ;
  assign strobes.openEn    = mainQ[OPEN_BIT];
  assign strobes.globalEn  = mainQ[GLOBAL_BIT];
  assign strobes.highEn    = extQ[HIGH_BIT];
  assign strobes.tsegEn    = extQ[TEN_BIT];
  assign strobes.tsegSize  = extQ[TSIZE_LSB +: 2];

endmodule

// File: rtl/smram_guard_dp.sv
module smram_guard_dp
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter int WIN_BYTES = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      strobes,
  input  logic [ADDR_W-1:0] topOfLow,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  output logic              rspValid,
  output logic [1:0]        rspRoute,
  output logic [DATA_W-1:0] holeData
);

  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] LOW_LAST  = LOW_BASE + WIN_SPAN - 1'b1;
  localparam logic [ADDR_W-1:0] HIGH_LAST = HIGH_BASE + WIN_SPAN - 1'b1;

  logic [ADDR_W:0] tsegBytes;
  logic            inLow, inHigh, inTseg;
  route_e          route;

  always_comb begin
    unique case (strobes.tsegSize)
      2'b00:   tsegBytes = (ADDR_W+1)'(1) << 20;
      2'b01:   tsegBytes = (ADDR_W+1)'(1) << 21;
      2'b10:   tsegBytes = (ADDR_W+1)'(1) << 23;
      default: tsegBytes = '0;
    endcase
    if (!strobes.tsegEn) tsegBytes = '0;
  end

  assign inLow  = (reqAddr >= LOW_BASE)  && (reqAddr <= LOW_LAST);
  assign inHigh = (reqAddr >= HIGH_BASE) && (reqAddr <= HIGH_LAST);
  assign inTseg = (tsegBytes != '0) && (reqAddr < topOfLow) &&
                  (({1'b0, reqAddr} + tsegBytes) >= {1'b0, topOfLow});

  always_comb begin
    route = ROUTE_NONE;
    if (inLow)  route = (strobes.openEn && !strobes.highEn) ? ROUTE_DRAM : ROUTE_PCI;
    if (inHigh) route = (strobes.openEn &&  strobes.highEn) ? ROUTE_DRAM : ROUTE_NONE;
    if (reqSmm && strobes.globalEn) begin
      if (inLow  && !strobes.highEn) route = ROUTE_DRAM;
      if (inHigh &&  strobes.highEn) route = ROUTE_DRAM;
    end
    if (inTseg) route = reqSmm ? ROUTE_DRAM : ROUTE_HOLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRoute <= ROUTE_NONE;
      holeData <= '0;
    end else begin
      rspValid <= reqValid;
      rspRoute <= reqValid ? route : ROUTE_NONE;
      holeData <= (reqValid && route == ROUTE_HOLE) ? '1 : '0;
    end
  end

endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  smramByte,
  output logic [7:0]  extByte,
  input  logic [31:0] topOfLow,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  output logic        rspValid,
  output logic [1:0]  rspRoute,
  output logic [31:0] holeData
);

  ctl_strobes_t strobes;

  smram_guard_ctl ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .smramByte(smramByte), .extByte(extByte),
    .strobes(strobes)
  );

  smram_guard_dp #(.ADDR_W(32), .DATA_W(32)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .topOfLow(topOfLow),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSmm(reqSmm),
    .rspValid(rspValid), .rspRoute(rspRoute), .holeData(holeData)
  );

endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqSmm,
  input logic [7:0]  smramByte,
  input logic [7:0]  extByte,
  input logic        rspValid,
  input logic [1:0]  rspRoute
);

  // R3
  lock_closes_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    smramByte[4] |-> !smramByte[6]);

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(smramByte[4]) |-> smramByte[4]);

  // R3
  ext_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(smramByte[4]) |-> $stable(extByte));

  // R3
  main_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(smramByte[4]) |-> (smramByte[7:6] == $past(smramByte[7:6]) &&
                             smramByte[4:0] == $past(smramByte[4:0])));

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    smramByte[2:0] == 3'b010 && extByte[6:3] == 4'b0000);

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid));

  // R8
  hole_only_non_smm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRoute == 2'd2) |-> !$past(reqSmm));

endmodule

bind smram_guard smram_guard_chk chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSmm(reqSmm),
  .smramByte(smramByte), .extByte(extByte),
  .rspValid(rspValid), .rspRoute(rspRoute)
);

// File: tb/smram_guard_test.sv
`timescale 1ns/1ps
module smram_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  smramByte, extByte;
  logic [31:0] topOfLow = 32'h8000_0000;
  logic        reqValid = 1'b0, reqSmm = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic [1:0]  rspRoute;
  logic [31:0] holeData;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smram_guard uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic req(input logic [31:0] a, input logic smm,
                     output logic [1:0] r, output logic [31:0] hd, output logic v);
    reqValid = 1'b1; reqAddr = a; reqSmm = smm;
    @(negedge clk);
    r = rspRoute; hd = holeData; v = rspValid;
    reqValid = 1'b0;
  endtask

  function automatic logic [1:0] model(input bit op, input bit g, input bit h, input bit ten,
                                       input int sz, input bit smm, input logic [31:0] a);
    longint tb, tolL, al;
    bit lo, hi;
    tolL = longint'(topOfLow); al = longint'(a);
    tb = !ten ? 0 : (sz == 0 ? 64'h10_0000 : sz == 1 ? 64'h20_0000 : sz == 2 ? 64'h80_0000 : 0);
    if (tb != 0 && al < tolL && al >= tolL - tb) return smm ? 2'd0 : 2'd2;
    lo = (al >= 64'hA0000) && (al <= 64'hBFFFF);
    hi = (al >= 64'hFEDA_0000) && (al <= 64'hFEDB_FFFF);
    if (smm && g) begin
      if (lo && !h) return 2'd0;
      if (hi && h)  return 2'd0;
    end
    if (lo) return (op && !h) ? 2'd0 : 2'd1;
    if (hi) return (op && h) ? 2'd0 : 2'd3;
    return 2'd3;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [1:0]  r;
    logic [31:0] hd;
    logic        v;
    logic [31:0] addrs [14];
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1 main", {24'h0, smramByte}, 32'h02);
    chk("R1 ext", {24'h0, extByte}, 32'h00);
    chk("R1 valid", {31'h0, rspValid}, 32'h0);
    chk("R1 route", {30'h0, rspRoute}, 32'h3);
    chk("R1 hole", holeData, 32'h0);

    // R2 write masks
    wr(1'b0, 8'hEF); chk("R2 main ones", {24'h0, smramByte}, 32'h6A);
    wr(1'b0, 8'h00); chk("R2 main zeros", {24'h0, smramByte}, 32'h02);
    wr(1'b1, 8'hFF); chk("R2 ext ones", {24'h0, extByte}, 32'h87);
    wr(1'b1, 8'h00); chk("R2 ext zeros", {24'h0, extByte}, 32'h00);

    // R9 idle gives no response
    @(negedge clk);
    chk("R9 idle valid", {31'h0, rspValid}, 32'h0);

    // sweep R4 R5 R6 R7 R8 R10
    for (int c = 0; c < 64; c++) begin
      bit op, g, h, ten, smm;
      int sz;
      logic [31:0] tsz;
      op = c[0]; g = c[1]; h = c[2]; ten = c[3]; sz = (c >> 4) & 3;
      tsz = (sz == 0) ? 32'h10_0000 : (sz == 1) ? 32'h20_0000 : (sz == 2) ? 32'h80_0000 : 32'h0;
      addrs[0] = 32'h9FFFF;     addrs[1] = 32'hA0000;  addrs[2] = 32'hBFFFF;
      addrs[3] = 32'hC0000;     addrs[4] = 32'hFED9_FFFF; addrs[5] = 32'hFEDA_0000;
      addrs[6] = 32'hFEDB_FFFF; addrs[7] = 32'hFEDC_0000; addrs[8] = topOfLow - 1;
      addrs[9] = topOfLow - tsz; addrs[10] = topOfLow - tsz - 1; addrs[11] = topOfLow;
      addrs[12] = topOfLow - 32'h80_0000; addrs[13] = 32'h0;
      wr(1'b0, {1'b0, op, 2'b00, g, 3'b010});
      wr(1'b1, {h, 4'b0, sz[1:0], ten});
      for (int s = 0; s < 2; s++) begin
        smm = s[0];
        for (int k = 0; k < 14; k++) begin
          logic [1:0] e;
          string tag;
          e = model(op, g, h, ten, sz, smm, addrs[k]);
          if (k >= 8 && k <= 12) tag = (e == 2'd2 || (smm && e == 2'd0)) ? "R8 tseg" : "R7 tseg edge";
          else if (smm) tag = "R6 smm view";
          else if (op) tag = "R4 open view";
          else tag = "R5 closed view";
          req(addrs[k], smm, r, hd, v);
          chk($sformatf("%s cfg=%0d smm=%0d a=%h", tag, c, smm, addrs[k]), {30'h0, r}, {30'h0, e});
          chk($sformatf("R9 hole data a=%h", addrs[k]), hd, (e == 2'd2) ? 32'hFFFF_FFFF : 32'h0);
          chk("R9 valid", {31'h0, v}, 32'h1);
        end
      end
      // R10: change open then immediately request
      @(negedge clk);
      cfgWrEn = 1'b1; cfgSel = 1'b0; cfgWrData = {1'b0, ~op, 2'b00, g, 3'b010};
      @(negedge clk);
      cfgWrEn = 1'b0;
      req(32'hA0000, 1'b0, r, hd, v);
      chk("R10 fresh cfg", {30'h0, r}, {30'h0, model(~op, g, h, ten, sz, 1'b0, 32'hA0000)});
    end

    // R3 lock
    doReset();
    wr(1'b1, 8'h81);
    wr(1'b0, 8'h58);
    chk("R3 lock clears open", {24'h0, smramByte}, 32'h1A);
    req(32'hA0000, 1'b0, r, hd, v);
    chk("R3 low window closed", {30'h0, r}, 32'h1);
    wr(1'b0, 8'h78);
    chk("R3 only closed bit", {24'h0, smramByte}, 32'h3A);
    wr(1'b0, 8'h00);
    chk("R3 lock sticky", {24'h0, smramByte}, 32'h1A);
    wr(1'b1, 8'h00);
    chk("R3 ext frozen", {24'h0, extByte}, 32'h81);
    req(32'hFEDA_0000, 1'b1, r, hd, v);
    chk("R3 smm high kept", {30'h0, r}, 32'h0);
    doReset();
    @(negedge clk);
    chk("R1 reset unlocks", {24'h0, smramByte}, 32'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule